// File: doc/BRIEF.md
# Current-Chopping H-Bridge Controller

This block is the digital core of a single H-bridge motor stage. It turns a two-bit direction/PWM command into the four gate enables of the bridge: a high-side and a low-side switch on each of the two legs. When the command selects one of the two directions, the block runs a fixed-period chopping cycle. Each period begins with the bridge driven in the commanded direction. The current-limit comparator is ignored for a blanking window, so that window is also the shortest possible on-time. Once the comparator trips, the block applies a decay pattern for the rest of the period.

A 2-bit decay select picks the pattern. Slow decay turns on both low-side switches. Fast decay reverses the bridge and then opens every switch when the current-near-zero flag reports that the winding has drained. Mixed decay uses fast decay at first and changes to slow decay three quarters of the way through the period. The two static commands, both-low and both-high, pass straight to the gates. The period counter keeps running while either static command is applied.

Every gate change goes through a per-leg dead-time stage. This stage guarantees that the two switches of one leg are never on together.

Top module: `hb_chop_ctrl`

## Requirements
- R1: While `rst_ni` is low, all four gate enables are 0.
- R2: Command `{in1_i,in2_i}` = 00 requests both low-side gates and 11 requests both high-side gates, at every point of the period and whatever the value of `ilim_i`. OUT high means the high-side gate is on; OUT low means the low-side gate is on.
- R3: Command 10 drives OUT1 high and OUT2 low, so `hs1_o` and `ls2_o` are on. Command 01 drives OUT1 low and OUT2 high, so `ls1_o` and `hs2_o` are on. This drive phase starts at period position 0 of each `PERIOD_CYC`-cycle period, counted from reset release.
- R4: The block ignores `ilim_i` while the period position is below `BLANK_CYC`. `BLANK_CYC` is 3750 ns at `CLK_MHZ` rounded up to whole cycles (15 at 4 MHz). A comparator pulse seen only inside this window leaves the drive on for the whole period.
- R5: If `ilim_i` is high when the period position is p ≥ `BLANK_CYC`, the decay request starts at position p+1 and holds until the period ends. Drive is requested again at position 0.
- R6: Decay select 00 means slow decay: both low-side gates are requested.
- R7: Decay select 11 means fast decay. The request is the reverse of the drive direction. If `izero_i` is high in any decay cycle, all four gates are requested off from the next cycle until the period ends. `izero_i` has no effect during the drive phase.
- R8: Decay selects 01 and 10 (the undriven pin) mean mixed decay. The block uses fast decay while the period position is below 3·`PERIOD_CYC`/4 and slow decay from that position to the end of the period.
- R9: The gates follow the request one clock edge later. A gate turns off at once. A gate turns on only after both gates of its leg have been off for `DEAD_CYC` cycles, or at the first edge after reset.
- R10: The high-side and low-side gates of one leg are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, `CLK_MHZ` MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in1_i | input | 1 | Command bit for OUT1 |
| in2_i | input | 1 | Command bit for OUT2 |
| ilim_i | input | 1 | Synchronized current-limit comparator flag |
| izero_i | input | 1 | Current-near-zero flag |
| decay_sel_i | input | 2 | Decay select: 00 slow, 11 fast, 01/10 mixed |
| hs1_o | output | 1 | OUT1 high-side gate enable |
| ls1_o | output | 1 | OUT1 low-side gate enable |
| hs2_o | output | 1 | OUT2 high-side gate enable |
| ls2_o | output | 1 | OUT2 low-side gate enable |

## Verification
A comparator trip sampled at period position p changes the request at p+1, and the gates change at p+2. When a gate moves from one side of a leg to the other, the leg is off at positions p+2 and p+3 and the new gate turns on at p+4 (with `DEAD_CYC` = 2). A current-near-zero flag seen at position q opens the gates at q+2. A command change made in cycle c shows on the gates after c+1 edges, or after c+1+`DEAD_CYC` edges if a leg flips. The bench counts edges from reset release, so it always knows the period position. It drives inputs and reads the gates on falling edges, at exactly these positions.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

  typedef enum logic {
    PH_DRIVE = 1'b0,
    PH_DECAY = 1'b1
  } phase_e;

  localparam logic [1:0] DK_SLOW = 2'b00;
  localparam logic [1:0] DK_FAST = 2'b11;
endpackage

// File: rtl/hb_period_timer.sv
module hb_period_timer #(
  parameter int unsigned PERIOD_CYC = 40,
  parameter int unsigned BLANK_CYC  = 15,
  parameter int unsigned MIX_CYC    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o,
  output logic sense_en_o,
  output logic late_o
);
  localparam int unsigned CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o     = (cnt_q == CW'(PERIOD_CYC - 1));
  assign sense_en_o = (cnt_q >= CW'(BLANK_CYC));
  assign late_o     = (cnt_q >= CW'(MIX_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/hb_chop_fsm.sv
module hb_chop_fsm
  import hb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   last_i,
  input  logic   sense_en_i,
  input  logic   ilim_i,
  input  logic   izero_i,
  output phase_e phase_o,
  output logic   zero_o
);
  phase_e phase_q, phase_d;
  logic   zero_q, zero_d;

  always_comb begin
    phase_d = phase_q;
    zero_d  = zero_q;
    if (last_i) begin
      phase_d = PH_DRIVE;
      zero_d  = 1'b0;
    end else begin
      if (phase_q == PH_DRIVE && sense_en_i && ilim_i) phase_d = PH_DECAY;
      if (phase_q == PH_DECAY && izero_i)              zero_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DRIVE;
      zero_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      zero_q  <= zero_d;
    end
  end

  assign phase_o = phase_q;
  assign zero_o  = zero_q;
endmodule

// File: rtl/hb_leg_request.sv
module hb_leg_request
  import hb_pkg::*;
(
  input  logic       in1_i,
  input  logic       in2_i,
  input  phase_e     phase_i,
  input  logic       zero_i,
  input  logic       late_i,
  input  logic [1:0] decay_sel_i,
  output leg_e       req1_o,
  output leg_e       req2_o
);
  logic mixed, slow_now;

  assign mixed    = (decay_sel_i != DK_SLOW) && (decay_sel_i != DK_FAST);
  assign slow_now = (decay_sel_i == DK_SLOW) || (mixed && late_i);

  always_comb begin
    if (in1_i == in2_i) begin
      req1_o = in1_i ? LEG_HI : LEG_LO;
      req2_o = req1_o;
    end else if (phase_i == PH_DRIVE) begin
      req1_o = in1_i ? LEG_HI : LEG_LO;
      req2_o = in2_i ? LEG_HI : LEG_LO;
    end else if (slow_now) begin
      req1_o = LEG_LO;
      req2_o = LEG_LO;
    end else if (zero_i) begin
      req1_o = LEG_OFF;
      req2_o = LEG_OFF;
    end else begin
      // fast decay: bridge reversed
      req1_o = in1_i ? LEG_LO : LEG_HI;
      req2_o = in2_i ? LEG_LO : LEG_HI;
    end
  end
endmodule

// File: rtl/hb_leg_deadtime.sv
module hb_leg_deadtime
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  leg_e req_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);

  leg_e          cur_q, cur_d;
  logic [DW-1:0] off_q, off_d;

  always_comb begin
    cur_d = cur_q;
    off_d = off_q;
    if (cur_q != LEG_OFF) begin
      if (req_i != cur_q) begin
        cur_d = LEG_OFF;
        off_d = DW'(1);
      end
    end else begin
      if (off_q < DW'(DEAD_CYC)) off_d = off_q + DW'(1);
      if (req_i != LEG_OFF && off_q >= DW'(DEAD_CYC)) cur_d = req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LEG_OFF;
      off_q <= DW'(DEAD_CYC);
    end else begin
      cur_q <= cur_d;
      off_q <= off_d;
    end
  end

  assign hs_o = (cur_q == LEG_HI);
  assign ls_o = (cur_q == LEG_LO);
endmodule

// File: rtl/hb_chop_ctrl.sv
module hb_chop_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 4,
  parameter int unsigned PERIOD_CYC = 40,
  parameter int unsigned DEAD_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in1_i,
  input  logic       in2_i,
  input  logic       ilim_i,
  input  logic       izero_i,
  input  logic [1:0] decay_sel_i,
  output logic       hs1_o,
  output logic       ls1_o,
  output logic       hs2_o,
  output logic       ls2_o
);
  localparam int unsigned BLANK_NS  = 3750;
  localparam int unsigned BLANK_CYC = (CLK_MHZ * BLANK_NS + 999) / 1000;
  localparam int unsigned MIX_CYC   = (PERIOD_CYC * 3) / 4;
  localparam int unsigned N_LEG     = 2;

  logic   last, sense_en, late, zero;
  phase_e phase;
  leg_e   req [N_LEG];
  logic   hs  [N_LEG];
  logic   ls  [N_LEG];

  hb_period_timer #(
    .PERIOD_CYC (PERIOD_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .MIX_CYC    (MIX_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .last_o     (last),
    .sense_en_o (sense_en),
    .late_o     (late)
  );

  hb_chop_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .last_i     (last),
    .sense_en_i (sense_en),
    .ilim_i     (ilim_i),
    .izero_i    (izero_i),
    .phase_o    (phase),
    .zero_o     (zero)
  );

  hb_leg_request u_req (
    .in1_i       (in1_i),
    .in2_i       (in2_i),
    .phase_i     (phase),
    .zero_i      (zero),
    .late_i      (late),
    .decay_sel_i (decay_sel_i),
    .req1_o      (req[0]),
    .req2_o      (req[1])
  );

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    hb_leg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req[g]),
      .hs_o   (hs[g]),
      .ls_o   (ls[g])
    );
  end

  assign hs1_o = hs[0];
  assign ls1_o = ls[0];
  assign hs2_o = hs[1];
  assign ls2_o = ls[1];
endmodule

// File: rtl/hb_chop_ctrl_chk.sv
module hb_chop_ctrl_chk #(
  parameter int unsigned DEAD_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in1_i,
  input logic in2_i,
  input logic hs1_o,
  input logic ls1_o,
  input logic hs2_o,
  input logic ls2_o
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);

  logic [DW-1:0] off1_q, off2_q;

  // consecutive cycles each leg has been fully off, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off1_q <= DW'(DEAD_CYC);
      off2_q <= DW'(DEAD_CYC);
    end else begin
      if (hs1_o || ls1_o)             off1_q <= '0;
      else if (off1_q < DW'(DEAD_CYC)) off1_q <= off1_q + DW'(1);
      if (hs2_o || ls2_o)             off2_q <= '0;
      else if (off2_q < DW'(DEAD_CYC)) off2_q <= off2_q + DW'(1);
    end
  end

  p_no_shoot_leg1_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs1_o && ls1_o)) else $error("R10 leg1 shoot-through");

  p_no_shoot_leg2_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs2_o && ls2_o)) else $error("R10 leg2 shoot-through");

  p_dead_gap_leg1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hs1_o || ls1_o) && !$past(hs1_o || ls1_o)) |-> (off1_q >= DW'(DEAD_CYC)))
    else $error("R9 leg1 dead time short");

  p_dead_gap_leg2_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hs2_o || ls2_o) && !$past(hs2_o || ls2_o)) |-> (off2_q >= DW'(DEAD_CYC)))
    else $error("R9 leg2 dead time short");

  p_no_swap_leg1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs1_o |=> !ls1_o) else $error("R9 leg1 direct swap");

  p_static_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in1_i && in2_i && $past(in1_i && in2_i) && $past(in1_i && in2_i, 2))
      |-> (!ls1_o && !ls2_o)) else $error("R2 low side on under 11");
endmodule

bind hb_chop_ctrl hb_chop_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (.*);

// File: tb/tb_hb_chop_ctrl.sv
module tb_hb_chop_ctrl;
  localparam int PER  = 40;
  localparam int MHZ  = 4;
  localparam int DEAD = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in1 = 1'b0, in2 = 1'b0, ilim = 1'b0, izero = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       hs1, ls1, hs2, ls2;
  int         checks = 0;
  int         errors = 0;
  int         ncyc = 0;

  always #4 clk = ~clk;

  hb_chop_ctrl #(.CLK_MHZ(MHZ), .PERIOD_CYC(PER), .DEAD_CYC(DEAD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in1_i(in1), .in2_i(in2),
    .ilim_i(ilim), .izero_i(izero), .decay_sel_i(sel),
    .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2)
  );

  always @(posedge clk) if (rst_ni) ncyc <= ncyc + 1;

  // R10 every cycle
  always @(negedge clk) if (rst_ni) begin
    checks++;
    if ((hs1 && ls1) || (hs2 && ls2)) begin
      errors++;
      $display("FAIL R10 gates %b%b%b%b exp no leg with both on", hs1, ls1, hs2, ls2);
    end
  end

  task automatic wait_pos(input int p);
    @(negedge clk);
    while ((ncyc % PER) != p) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input string req);
    checks++;
    if ({hs1, ls1, hs2, ls2} !== exp) begin
      errors++;
      $display("FAIL %s pos %0d gates %b exp %b", req, ncyc % PER, {hs1, ls1, hs2, ls2}, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // BLANK = ceil(MHZ*3750/1000) = 15, mixed point 30; gates are {hs1,ls1,hs2,ls2}
    repeat (3) @(negedge clk);
    chk(4'b0000, "R1");
    rst_ni = 1'b1;
    wait_pos(3);  chk(4'b0101, "R2");
    in1 = 1'b1; in2 = 1'b1; ilim = 1'b1;
    wait_pos(4);  chk(4'b0000, "R9");
    wait_pos(5);  chk(4'b0000, "R9");
    wait_pos(6);  chk(4'b1010, "R2");
    wait_pos(30); chk(4'b1010, "R2");
    in2 = 1'b0; ilim = 1'b0; sel = 2'b11;
    // period 1: fast decay after trip
    wait_pos(0);  ilim = 1'b1;
    wait_pos(14); chk(4'b1001, "R4");
    wait_pos(16); chk(4'b1001, "R5");
    wait_pos(17); chk(4'b0000, "R9");
    wait_pos(18); chk(4'b0000, "R9");
    wait_pos(19); chk(4'b0110, "R7");
    wait_pos(24); izero = 1'b1;
    wait_pos(25); chk(4'b0110, "R7");
    wait_pos(26); chk(4'b0000, "R7");
    izero = 1'b0;
    wait_pos(35); chk(4'b0000, "R7");
    // period 2: drive resumes, pulse inside blanking only
    wait_pos(0);  chk(4'b0000, "R5");
    wait_pos(1);  chk(4'b1001, "R3");
    wait_pos(13); ilim = 1'b0;
    wait_pos(30); chk(4'b1001, "R4");
    izero = 1'b1;
    // period 3: izero during drive has no effect
    wait_pos(10); chk(4'b1001, "R7");
    wait_pos(30); chk(4'b1001, "R7");
    izero = 1'b0; sel = 2'b00;
    // period 4: slow decay
    wait_pos(0);  ilim = 1'b1;
    wait_pos(16); chk(4'b1001, "R5");
    wait_pos(17); chk(4'b0001, "R6");
    wait_pos(18); chk(4'b0001, "R9");
    wait_pos(19); chk(4'b0101, "R6");
    wait_pos(39); chk(4'b0101, "R6");
    ilim = 1'b0;
    wait_pos(0);  chk(4'b0101, "R5");
    wait_pos(1);  chk(4'b0001, "R9");
    wait_pos(2);  chk(4'b0001, "R9");
    wait_pos(3);  chk(4'b1001, "R3");
    sel = 2'b01;
    // period 6: mixed decay
    wait_pos(0);  ilim = 1'b1;
    wait_pos(19); chk(4'b0110, "R8");
    wait_pos(30); chk(4'b0110, "R8");
    wait_pos(31); chk(4'b0100, "R8");
    wait_pos(32); chk(4'b0100, "R9");
    wait_pos(33); chk(4'b0101, "R8");
    ilim = 1'b0;
    wait_pos(0);  chk(4'b0101, "R5");
    wait_pos(1);  chk(4'b0001, "R9");
    wait_pos(3);  chk(4'b1001, "R3");
    sel = 2'b10;
    // period 8: second mixed encoding
    wait_pos(0);  ilim = 1'b1;
    wait_pos(19); chk(4'b0110, "R8");
    wait_pos(31); chk(4'b0100, "R8");
    wait_pos(33); chk(4'b0101, "R8");
    sel = 2'b11; in1 = 1'b0; in2 = 1'b1; ilim = 1'b0;
    wait_pos(37); chk(4'b1001, "R7");
    // period 9: reverse direction with fast decay
    wait_pos(0);  ilim = 1'b1;
    wait_pos(1);  chk(4'b0000, "R9");
    wait_pos(10); chk(4'b0110, "R3");
    wait_pos(17); chk(4'b0000, "R9");
    wait_pos(19); chk(4'b1001, "R7");
    ilim = 1'b0;
    wait_pos(25);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule